// File: doc/BRIEF.md
# Serial Adapter Register Front End on a Parallel Byte Port

This block gives a processor the familiar register set of an asynchronous serial adapter: a data register, a status register, a command register and a control register. No serial shifter sits behind it. Bytes the CPU writes go out on a byte-wide port with a valid/ready handshake, and bytes arriving on a byte-wide input with a valid strobe land in the receive register. Software written for the serial adapter can therefore drive a parallel link unchanged.

The interrupt logic follows a flip-flop-per-source scheme. A receive flag is latched when the receive register goes from empty to full. A clear-to-send flag is latched when the clear-to-send input goes inactive. Transmit-empty drives the interrupt directly as a level. Each source is gated by its enable in the command register, and the gated sources are combined into one active-low interrupt output. Reading status drops the latched flags. Writing the status address performs a soft reset. Only the low four command bits exist.

Top module: `acia_regfront`

## Requirements
- R1: Register select 0 reads the received byte and writes the transmit byte. Select 2 reads the command register in bits 3:0, with upper bits reading 0 and upper write bits dropped. Select 3 reads 0, and writes to it change nothing.
- R2: A status read returns the interrupt state in bit 7 (1 exactly when irq_n is low), transmit-empty in bit 4, receive-full in bit 3 and overrun in bit 2. Every other bit reads 0.
- R3: After hard reset, status reads 0x10, command reads 0x00 and irq_n is 1.
- R4: A byte on rx_valid stores into an empty receive register and sets receive-full. A data read clears receive-full and overrun.
- R5: A byte arriving while receive-full is set is discarded, keeps the stored byte and sets overrun.
- R6: A receive interrupt is latched when a byte fills the empty receive register, and is visible when command bit 1 is 0 (including a latch made while disabled). A status read clears it, and an unread byte does not raise it again.
- R7: A data write clears transmit-empty. The byte is offered on tx_data with tx_valid only while command bit 0 is 1 and cts_n is low, and a tx_valid/tx_ready handshake sets transmit-empty.
- R8: While command bits 3:2 equal 01 and transmit-empty is set, irq_n is low. This persists across status reads and ends on a data write.
- R9: A rise of cts_n latches a flag that pulls irq_n low while command bits 3:2 equal 01. It appears only as status bit 7 and is cleared by a status read.
- R10: Any write to select 1 clears receive-full, overrun and all interrupt flags, sets transmit-empty and zeroes the command register, so irq_n is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_addr | input | 2 | Register select |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while a read is selected |
| irq_n | output | 1 | Active-low interrupt |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | DATA_W | Incoming byte |
| tx_valid | output | 1 | Outgoing byte offered |
| tx_ready | input | 1 | Outgoing byte accepted |
| tx_data | output | DATA_W | Outgoing byte |
| cts_n | input | 1 | Clear-to-send, active low |

## Verification
A lost or stuck receive latch shows on irq_n one cycle after the byte strobe, and on status bit 7 at the next status read. A wrong full, empty or overrun flag shows in that same read. A transmit holding fault shows at the tx handshake as a missing, extra or altered byte, and also as a transmit-empty bit that disagrees with the last write. Scenarios are ordered so that every flag is read both before and after the event that should clear it, including reads that must leave it alone.

// File: rtl/acia_pkg.sv
package acia_pkg;
   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CMD  = 2'd2,
      SEL_CTRL = 2'd3
   } reg_sel_e;

   localparam int CMD_W      = 4;
   localparam int ST_IRQ     = 7;
   localparam int ST_TXE     = 4;
   localparam int ST_RXF     = 3;
   localparam int ST_OVR     = 2;
   localparam int CMD_TXON   = 0;
   localparam int CMD_RXOFF  = 1;

   function automatic logic tx_irq_on(input logic [CMD_W-1:0] c);
      return c[3:2] == 2'b01;
   endfunction
endpackage

// File: rtl/acia_rx_buf.sv
module acia_rx_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rd_take,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] buf_q,
   output logic              full,
   output logic              ovr,
   output logic              fill
);
   logic accept;

   assign accept = in_valid && (!full || rd_take) && !clr;
   assign fill   = in_valid && !full && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         full <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (accept)       full <= 1'b1;
         else if (rd_take) full <= 1'b0;
         if (in_valid && full && !rd_take) ovr <= 1'b1;
         else if (rd_take)                 ovr <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      buf_q <= '0;
      else if (accept) buf_q <= in_data;
   end
endmodule

// File: rtl/acia_tx_hold.sv
module acia_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              send_ok,
   input  logic              ready,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              empty
);
   assign valid = !empty && send_ok;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)        empty <= 1'b1;
      else if (load)            empty <= 1'b0;
      else if (valid && ready)  empty <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    data <= '0;
      else if (load) data <= load_data;
   end
endmodule

// File: rtl/acia_irq_ctl.sv
module acia_irq_ctl #(
   parameter bit CTS_SRC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stat_rd,
   input  logic rx_fill,
   input  logic tx_empty,
   input  logic cts_n,
   input  logic rx_en,
   input  logic tx_en,
   output logic irq_n
);
   logic rx_flag;
   logic cts_flag;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  rx_flag <= 1'b0;
      else if (rx_fill)   rx_flag <= 1'b1;
      else if (stat_rd)   rx_flag <= 1'b0;
   end

   generate
      if (CTS_SRC) begin : g_cts
         logic cts_d;
         always_ff @(posedge clk) begin
            if (!rst_n) cts_d <= 1'b1;
            else        cts_d <= cts_n;
         end
         always_ff @(posedge clk) begin
            if (!rst_n || clr)        cts_flag <= 1'b0;
            else if (cts_n && !cts_d) cts_flag <= 1'b1;
            else if (stat_rd)         cts_flag <= 1'b0;
         end
      end else begin : g_no_cts
         assign cts_flag = 1'b0;
      end
   endgenerate

   assign irq_n = !((rx_flag && rx_en) || (tx_empty && tx_en) || (cts_flag && tx_en));
endmodule

// File: rtl/acia_regfront.sv
module acia_regfront
   import acia_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit CTS_SRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic [1:0]        cpu_addr,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              irq_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   input  logic              cts_n
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("acia_regfront: DATA_W must be at least 8");
      end
   endgenerate

   reg_sel_e          sel;
   logic              rd_any, wr_any;
   logic              data_rd, data_wr, stat_rd, soft_rst, cmd_wr;
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] rx_byte, stat_word;
   logic              rx_full, ovr_flag, rx_fill, tx_empty;

   assign sel      = reg_sel_e'(cpu_addr);
   assign rd_any   = cpu_sel && !cpu_we;
   assign wr_any   = cpu_sel && cpu_we;
   assign data_rd  = rd_any && sel == SEL_DATA;
   assign data_wr  = wr_any && sel == SEL_DATA;
   assign stat_rd  = rd_any && sel == SEL_STAT;
   assign soft_rst = wr_any && sel == SEL_STAT;
   assign cmd_wr   = wr_any && sel == SEL_CMD;

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) cmd_q <= '0;
      else if (cmd_wr)        cmd_q <= cpu_wdata[CMD_W-1:0];
   end

   acia_rx_buf #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .rd_take(data_rd),
      .in_valid(rx_valid), .in_data(rx_data), .buf_q(rx_byte),
      .full(rx_full), .ovr(ovr_flag), .fill(rx_fill)
   );

   acia_tx_hold #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(data_wr),
      .load_data(cpu_wdata), .send_ok(cmd_q[CMD_TXON] && !cts_n),
      .ready(tx_ready), .valid(tx_valid), .data(tx_data), .empty(tx_empty)
   );

   acia_irq_ctl #(.CTS_SRC(CTS_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .stat_rd(stat_rd),
      .rx_fill(rx_fill), .tx_empty(tx_empty), .cts_n(cts_n),
      .rx_en(!cmd_q[CMD_RXOFF]), .tx_en(tx_irq_on(cmd_q)), .irq_n(irq_n)
   );

   always_comb begin
      stat_word         = '0;
      stat_word[ST_IRQ] = !irq_n;
      stat_word[ST_TXE] = tx_empty;
      stat_word[ST_RXF] = rx_full;
      stat_word[ST_OVR] = ovr_flag;
   end

   always_comb begin
      cpu_rdata = '0;
      if (rd_any) begin
         unique case (sel)
            SEL_DATA: cpu_rdata = rx_byte;
            SEL_STAT: cpu_rdata = stat_word;
            SEL_CMD:  cpu_rdata[CMD_W-1:0] = cmd_q;
            SEL_CTRL: cpu_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/acia_regfront_chk.sv
module acia_regfront_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_sel,
   input logic       cpu_we,
   input logic [1:0] cpu_addr,
   input logic       cpu_bit7,
   input logic       irq_n,
   input logic       rx_valid,
   input logic       tx_valid,
   input logic       cts_n,
   input logic       rx_full,
   input logic       ovr_flag,
   input logic       rx_off
);
   logic wr_stat, wr_cmd, rd_data;
   assign wr_stat = cpu_sel && cpu_we && cpu_addr == 2'd1;
   assign wr_cmd  = cpu_sel && cpu_we && cpu_addr == 2'd2;
   assign rd_data = cpu_sel && !cpu_we && cpu_addr == 2'd0;

   // R2
   p_bit7_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_sel && !cpu_we && cpu_addr == 2'd1) |-> (cpu_bit7 == !irq_n));

   // R7
   p_tx_needs_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !cts_n);

   // R10
   p_soft_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> irq_n);

   // R6
   p_rx_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_full && !rx_off && !wr_stat && !wr_cmd) |=> !irq_n);

   // R5
   p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full && !rd_data && !wr_stat) |=> ovr_flag);
endmodule

bind acia_regfront acia_regfront_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
   .cpu_addr(cpu_addr), .cpu_bit7(cpu_rdata[7]), .irq_n(irq_n),
   .rx_valid(rx_valid), .tx_valid(tx_valid), .cts_n(cts_n),
   .rx_full(rx_full), .ovr_flag(ovr_flag), .rx_off(cmd_q[1])
);

// File: tb/acia_regfront_tb_top.sv
`timescale 1ns/1ps
module acia_regfront_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_sel = 1'b0, cpu_we = 1'b0;
   logic [1:0] cpu_addr = 2'd0;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic       irq_n;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       tx_valid, tx_ready = 1'b0;
   logic [7:0] tx_data;
   logic       cts_n = 1'b0;

   int checks = 0, errors = 0;
   logic [7:0] rd_q[$];
   string      rd_tag[$];
   logic [7:0] tx_q[$];

   always #4 clk = !clk;

   acia_regfront dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
      .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .irq_n(irq_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .cts_n(cts_n)
   );

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // read monitor: pops expected values
   always @(negedge clk) begin
      if (cpu_sel && !cpu_we) begin
         checks++;
         if (rd_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read actual %h expected none", cpu_rdata);
         end else begin
            automatic logic [7:0] e = rd_q.pop_front();
            automatic string t = rd_tag.pop_front();
            if (cpu_rdata !== e) begin
               errors++;
               $display("FAIL %s read actual %h expected %h", t, cpu_rdata, e);
            end
         end
      end
   end

   // transmit monitor (R7)
   always @(negedge clk) begin
      if (tx_valid && tx_ready) begin
         checks++;
         if (tx_q.size() == 0) begin
            errors++;
            $display("FAIL R7 tx byte actual %h expected none", tx_data);
         end else begin
            automatic logic [7:0] e = tx_q.pop_front();
            if (tx_data !== e) begin
               errors++;
               $display("FAIL R7 tx byte actual %h expected %h", tx_data, e);
            end
         end
      end
   end

   task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(posedge clk); #1;
      cpu_sel = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic cpu_read(input logic [1:0] a, input logic [7:0] e, input string t);
      @(posedge clk); #1;
      rd_q.push_back(e); rd_tag.push_back(t);
      cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      @(posedge clk); #1;
      cpu_sel = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] d);
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = d;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic tx_accept(input logic [7:0] e);
      tx_q.push_back(e);
      @(posedge clk); #1; tx_ready = 1'b1;
      @(posedge clk); #1; tx_ready = 1'b0;
   endtask

   task automatic chk_bit(input logic act, input logic exp, input string t);
      @(negedge clk);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b", t, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual running expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R3 reset state
      chk_bit(irq_n, 1'b1, "R3 irq_n after reset");
      cpu_read(2'd1, 8'h10, "R3 status after reset");
      cpu_read(2'd2, 8'h00, "R3 command after reset");

      // R4 R6 receive and interrupt
      rx_push(8'h5A);
      chk_bit(irq_n, 1'b0, "R6 rx irq");
      cpu_read(2'd1, 8'h98, "R2 R6 status with rx");
      chk_bit(irq_n, 1'b1, "R6 irq cleared by status read");
      cpu_read(2'd1, 8'h18, "R6 no re-irq on unread byte");
      cpu_read(2'd0, 8'h5A, "R4 data read");
      cpu_read(2'd1, 8'h10, "R4 full cleared");

      // R5 overrun
      rx_push(8'h11);
      rx_push(8'h22);
      cpu_read(2'd1, 8'h9C, "R5 overrun status");
      cpu_read(2'd0, 8'h11, "R5 old byte kept");
      cpu_read(2'd1, 8'h10, "R4 overrun cleared by data read");

      // R6 gated enable
      cpu_write(2'd2, 8'h02);
      rx_push(8'h77);
      chk_bit(irq_n, 1'b1, "R6 rx irq disabled");
      cpu_write(2'd2, 8'h00);
      chk_bit(irq_n, 1'b0, "R6 pending latch visible on enable");
      cpu_read(2'd1, 8'h98, "R6 status pending");
      cpu_read(2'd0, 8'h77, "R4 data read");

      // R7 transmit
      cpu_write(2'd2, 8'h01);
      cpu_write(2'd0, 8'hA7);
      chk_bit(tx_valid, 1'b1, "R7 tx offered");
      cpu_read(2'd1, 8'h00, "R7 tx not empty");
      tx_accept(8'hA7);
      cpu_read(2'd1, 8'h10, "R7 tx empty after handshake");

      // R8 transmit interrupt level
      cpu_write(2'd2, 8'h05);
      chk_bit(irq_n, 1'b0, "R8 tx irq");
      cpu_read(2'd1, 8'h90, "R8 status");
      chk_bit(irq_n, 1'b0, "R8 persists after status read");
      cpu_write(2'd0, 8'h3C);
      chk_bit(irq_n, 1'b1, "R8 cleared by data write");
      tx_accept(8'h3C);
      chk_bit(irq_n, 1'b0, "R8 again after send");
      cpu_write(2'd2, 8'h01);

      // R9 clear-to-send
      @(posedge clk); #1 cts_n = 1'b1;
      chk_bit(irq_n, 1'b1, "R9 cts flag gated off");
      cpu_write(2'd0, 8'h66);
      chk_bit(tx_valid, 1'b0, "R7 tx held while cts high");
      cpu_write(2'd2, 8'h05);
      chk_bit(irq_n, 1'b0, "R9 cts irq");
      cpu_read(2'd1, 8'h80, "R9 only bit7");
      chk_bit(irq_n, 1'b1, "R9 cleared by status read");
      @(posedge clk); #1 cts_n = 1'b0;
      tx_accept(8'h66);
      cpu_write(2'd2, 8'h01);

      // R10 soft reset
      rx_push(8'h44);
      cpu_write(2'd2, 8'h05);
      cpu_write(2'd1, 8'hFF);
      chk_bit(irq_n, 1'b1, "R10 irq after soft reset");
      cpu_read(2'd1, 8'h10, "R10 status after soft reset");
      cpu_read(2'd2, 8'h00, "R10 command zeroed");

      // R1 decode
      cpu_write(2'd3, 8'hFF);
      cpu_read(2'd3, 8'h00, "R1 control reads zero");
      cpu_read(2'd2, 8'h00, "R1 control write ignored");
      cpu_write(2'd2, 8'hF3);
      cpu_read(2'd2, 8'h03, "R1 upper command bits dropped");
      cpu_write(2'd2, 8'h00);

      repeat (3) @(posedge clk);
      if (rd_q.size() != 0 || tx_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R7 leftover items actual %0d expected 0", rd_q.size() + tx_q.size());
      end
      summary();
      $finish;
   end
endmodule